// File: doc/BRIEF.md
# Byte/Word Add-Subtract Unit with Status Flags

This block does the integer add and subtract work of a small 16-bit processor datapath. Each request carries a destination operand, a source operand, the carry bit currently held in the processor's flag register, a 3-bit operation code and a size bit that picks byte or word width. The unit returns the sized result and six status flags: carry, overflow, zero, sign, parity and nibble (auxiliary) carry. The flag rules are what conditional branches and multiword carry chains depend on.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through a single output register, so there is one cycle of latency. A request is taken on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput when the consumer keeps `out_ready` high. While the consumer holds `out_ready` low, a pending result and its flags stay frozen at the output and no new request is taken.

All arithmetic is done by one chain of 4-bit carry slices. Each operation is turned into an addition by choosing what drives the two chain inputs and its carry-in.

Top module: `addsub_flag_unit`

## Requirements
- R1: Operation codes 0, 1, 2 and 7 compute, at the selected size, dst+src, dst+src+carry_in, dst+1 and dst+src respectively.
- R2: Operation codes 3, 4, 5 and 6 compute, at the selected size, dst-src, dst-src-carry_in, dst-1 and 0-dst respectively.
- R3: `in_byte`=1 selects byte size and `in_byte`=0 selects word size. In byte mode the operands' upper bits are ignored, the result's upper byte is zero, and every flag is taken from the low 8 bits.
- R4: For codes 0, 1 and 7, CF is the carry out of the sized MSB. For codes 3 and 4, CF is the borrow out of the sized MSB. Codes 2 and 5 copy `in_carry` to CF unchanged.
- R5: For add-type codes (0, 1, 2, 7), OF is set when both addends have the same sign and the result's sign differs from it. For subtract-type codes (3, 4, 5), OF is set when minuend and subtrahend differ in sign and the result's sign differs from the minuend's. For code 6, OF is set exactly when dst is the most negative value of the selected size.
- R6: ZF is set exactly when the sized result is zero. SF equals the sized result's MSB.
- R7: PF is set when result bits 7:0 contain an even number of ones. AF is the carry (add-type codes) or borrow (subtract-type codes and code 6) between bit 3 and bit 4.
- R8: Code 6 sets CF unless the sized dst is zero. Negating zero gives result 0 with CF=0 and ZF=1.
- R9: A request is accepted when `in_valid` and `in_ready` are both high at a rising edge, and its result appears with `out_valid` on the next cycle. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, the result and flags hold steady. Results leave in the order the requests were accepted.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 3 | Operation code |
| in_byte | input | 1 | 1 = byte size, 0 = word size |
| in_dst | input | W | Destination operand |
| in_src | input | W | Source operand |
| in_carry | input | 1 | Carry bit from the flag register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | W | Sized result |
| out_cf | output | 1 | Carry/borrow flag |
| out_of | output | 1 | Signed overflow flag |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag |
| out_pf | output | 1 | Even parity of result bits 7:0 |
| out_af | output | 1 | Nibble carry/borrow flag |

## Verification
Some properties are checked on every cycle. Stall holding and valid-after-accept are checked at the stream edge. The chain-driven flags are checked in three cases: the upper byte is zero after a byte request, increment and decrement pass the carry through, and negating zero gives CF=0 with ZF=1. The arithmetic itself can only be shown by the bench's scenarios. These cover the worked vectors (0x1234+0x00CD, 0xAB+0x05, negate 0xB0, 0x1301-0x0012, increment 0x00CD), the overflow and parity corners at both sizes, and borrow chains with carry in set. Several hundred random requests are run under random back-pressure and compared field by field against an integer model, and that model also confirms ordering.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_INC = 3'd2,
    OP_SUB = 3'd3,
    OP_SBB = 3'd4,
    OP_DEC = 3'd5,
    OP_NEG = 3'd6,
    OP_ALT = 3'd7
  } op_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic zf;
    logic sf;
    logic pf;
    logic af;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  function automatic logic even_parity8(input logic [7:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic         is_byte,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic         carry_in,
  output logic [W-1:0] chain_a,
  output logic [W-1:0] chain_b,
  output logic         chain_cin,
  output logic         a_sign,
  output logic         b_sign,
  output logic         is_sub,
  output logic         keep_cf
);

  localparam logic [W-1:0] BYTE_MASK = {{(W-8){1'b0}}, 8'hFF};
  localparam logic [W-1:0] ONE       = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] size_mask;
  logic [W-1:0] d_m;
  logic [W-1:0] s_m;

  always_comb begin
    size_mask = is_byte ? BYTE_MASK : '1;
    d_m       = dst & size_mask;
    s_m       = src & size_mask;

    chain_a   = d_m;
    chain_b   = s_m;
    chain_cin = 1'b0;
    is_sub    = 1'b0;
    keep_cf   = 1'b0;

    unique case (op_e'(op))
      OP_ADC: chain_cin = carry_in;
      OP_INC: begin
        chain_b = ONE;
        keep_cf = 1'b1;
      end
      OP_SUB: begin
        chain_b   = ~s_m & size_mask;
        chain_cin = 1'b1;
        is_sub    = 1'b1;
      end
      OP_SBB: begin
        chain_b   = ~s_m & size_mask;
        chain_cin = ~carry_in;
        is_sub    = 1'b1;
      end
      OP_DEC: begin
        chain_b   = ~ONE & size_mask;
        chain_cin = 1'b1;
        is_sub    = 1'b1;
        keep_cf   = 1'b1;
      end
      OP_NEG: begin
        chain_a   = '0;
        chain_b   = ~d_m & size_mask;
        chain_cin = 1'b1;
        is_sub    = 1'b1;
      end
      default: begin
        chain_b   = s_m;
        chain_cin = 1'b0;
      end
    endcase

    a_sign = is_byte ? chain_a[7] : chain_a[W-1];
    b_sign = is_byte ? chain_b[7] : chain_b[W-1];
  end

endmodule

// File: rtl/addsub_nibble_chain.sv
module addsub_nibble_chain #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_nib,
  output logic         c_byte,
  output logic         c_word
);

  localparam int NIB      = W / 4;
  localparam int BYTE_NIB = 2;

  logic [NIB:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < NIB; g++) begin : g_slice
    logic [4:0] part;
    assign part = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0000, carry[g]};
    assign sum[4*g +: 4] = part[3:0];
    assign carry[g+1]    = part[4];
  end

  assign c_nib  = carry[1];
  assign c_byte = carry[BYTE_NIB];
  assign c_word = carry[NIB];

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
  import addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] sum,
  input  logic         c_nib,
  input  logic         c_byte,
  input  logic         c_word,
  input  logic         a_sign,
  input  logic         b_sign,
  input  logic         is_byte,
  input  logic         is_sub,
  input  logic         keep_cf,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output flags_t       flags
);

  logic raw_carry;
  logic r_sign;

  always_comb begin
    result    = is_byte ? {{(W-8){1'b0}}, sum[7:0]} : sum;
    raw_carry = is_byte ? c_byte : c_word;
    r_sign    = is_byte ? sum[7] : sum[W-1];

    flags.cf = keep_cf ? carry_in : (raw_carry ^ is_sub);
    flags.of = (a_sign == b_sign) && (r_sign != a_sign);
    flags.zf = (result == '0);
    flags.sf = r_sign;
    flags.pf = even_parity8(sum[7:0]);
    flags.af = c_nib ^ is_sub;
  end

endmodule

// File: rtl/addsub_out_stage.sv
module addsub_out_stage #(
  parameter int DW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          load;

  assign in_ready  = !valid_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= in_data;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   in_op,
  input  logic         in_byte,
  input  logic [W-1:0] in_dst,
  input  logic [W-1:0] in_src,
  input  logic         in_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_cf,
  output logic         out_of,
  output logic         out_zf,
  output logic         out_sf,
  output logic         out_pf,
  output logic         out_af
);

  localparam int DW = W + FLAG_W;

  logic [W-1:0] chain_a;
  logic [W-1:0] chain_b;
  logic         chain_cin;
  logic         a_sign;
  logic         b_sign;
  logic         is_sub;
  logic         keep_cf;
  logic [W-1:0] sum;
  logic         c_nib;
  logic         c_byte;
  logic         c_word;
  logic [W-1:0] result;
  flags_t       flags;
  flags_t       flags_q;
  logic [DW-1:0] stage_out;

  addsub_operand_prep #(.W(W)) u_prep (
    .op        (in_op),
    .is_byte   (in_byte),
    .dst       (in_dst),
    .src       (in_src),
    .carry_in  (in_carry),
    .chain_a   (chain_a),
    .chain_b   (chain_b),
    .chain_cin (chain_cin),
    .a_sign    (a_sign),
    .b_sign    (b_sign),
    .is_sub    (is_sub),
    .keep_cf   (keep_cf)
  );

  addsub_nibble_chain #(.W(W)) u_chain (
    .a      (chain_a),
    .b      (chain_b),
    .cin    (chain_cin),
    .sum    (sum),
    .c_nib  (c_nib),
    .c_byte (c_byte),
    .c_word (c_word)
  );

  addsub_flag_gen #(.W(W)) u_flags (
    .sum      (sum),
    .c_nib    (c_nib),
    .c_byte   (c_byte),
    .c_word   (c_word),
    .a_sign   (a_sign),
    .b_sign   (b_sign),
    .is_byte  (in_byte),
    .is_sub   (is_sub),
    .keep_cf  (keep_cf),
    .carry_in (in_carry),
    .result   (result),
    .flags    (flags)
  );

  addsub_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({result, flags}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_result = stage_out[DW-1:FLAG_W];
  assign flags_q    = stage_out[FLAG_W-1:0];
  assign out_cf     = flags_q.cf;
  assign out_of     = flags_q.of;
  assign out_zf     = flags_q.zf;
  assign out_sf     = flags_q.sf;
  assign out_pf     = flags_q.pf;
  assign out_af     = flags_q.af;

  logic take;
  logic dst_sized_zero;
  assign take           = in_valid && in_ready;
  assign dst_sized_zero = in_byte ? (in_dst[7:0] == 8'h00) : (in_dst == '0);

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_byte) |=> (out_result[W-1:8] == '0)); // R3

  AST_STEP_KEEPS_CF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == 3'(OP_INC) || in_op == 3'(OP_DEC)))
      |=> (out_cf == $past(in_carry))); // R4

  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 3'(OP_NEG) && dst_sized_zero) |=> (!out_cf && out_zf)); // R8

endmodule

// File: tb/test_addsub_flag_unit.sv
`timescale 1ns/1ps
module test_addsub_flag_unit;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic          in_byte = 1'b0;
  logic [W-1:0]  in_dst = '0;
  logic [W-1:0]  in_src = '0;
  logic          in_carry = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_result;
  logic          out_cf, out_of, out_zf, out_sf, out_pf, out_af;

  always #2.5 clk = ~clk;

  addsub_flag_unit #(.W(W)) i_addsub_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_byte(in_byte), .in_dst(in_dst), .in_src(in_src),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cf(out_cf), .out_of(out_of), .out_zf(out_zf),
    .out_sf(out_sf), .out_pf(out_pf), .out_af(out_af)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        sz;
    logic [15:0] res;
    logic        cf, of, zf, sf, pf, af;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int n_sent = 0;
  int n_recv = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic sz,
                                 input logic [15:0] d_in, input logic [15:0] s_in,
                                 input logic c);
    exp_t e;
    int mask, top, d, s, s2, r;
    bit sub_like;
    logic [7:0] lo;
    mask = sz ? 255 : 65535;
    top  = sz ? 128 : 32768;
    d = int'(d_in) & mask;
    s = int'(s_in) & mask;
    e = '0;
    e.op = op;
    e.sz = sz;
    sub_like = 1'b0;
    s2 = s;
    case (op)
      3'd1: begin r = d + s + int'(c); e.cf = (r > mask); e.af = ((d & 15) + (s & 15) + int'(c)) > 15; end
      3'd2: begin s2 = 1; r = d + 1; e.cf = c; e.af = (d & 15) == 15; end
      3'd3: begin sub_like = 1'b1; r = d - s; e.cf = d < s; e.af = (d & 15) < (s & 15); end
      3'd4: begin sub_like = 1'b1; r = d - s - int'(c); e.cf = d < (s + int'(c)); e.af = (d & 15) < ((s & 15) + int'(c)); end
      3'd5: begin sub_like = 1'b1; s2 = 1; r = d - 1; e.cf = c; e.af = (d & 15) == 0; end
      3'd6: begin r = 0 - d; e.cf = d != 0; e.af = (d & 15) != 0; end
      default: begin r = d + s; e.cf = (r > mask); e.af = ((d & 15) + (s & 15)) > 15; end
    endcase
    r = r & mask;
    if (op == 3'd6)
      e.of = (d == top);
    else if (sub_like)
      e.of = (((d & top) != 0) != ((s2 & top) != 0)) && (((r & top) != 0) != ((d & top) != 0));
    else
      e.of = (((d & top) != 0) == ((s2 & top) != 0)) && (((r & top) != 0) != ((d & top) != 0));
    e.res = 16'(r);
    e.zf = (r == 0);
    e.sf = (r & top) != 0;
    lo = 8'(r);
    e.pf = ~(^lo);
    return e;
  endfunction

  task automatic send(input logic [2:0] op, input logic sz,
                      input logic [15:0] d, input logic [15:0] s, input logic c);
    in_valid = 1'b1;
    in_op = op; in_byte = sz; in_dst = d; in_src = s; in_carry = c;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    exp_q.push_back(model(op, sz, d, s, c));
    n_sent++;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor: the item shown now leaves at the coming edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        string rq;
        e = exp_q.pop_front();
        n_recv++;
        rq = (e.op inside {3'd0, 3'd1, 3'd2, 3'd7}) ? "R1" : "R2";
        check(rq, "result", int'(out_result), int'(e.res));
        if (e.sz) check("R3", "byte upper", int'(out_result[15:8]), 0);
        check((e.op == 3'd6) ? "R8" : "R4", "cf", int'(out_cf), int'(e.cf));
        check("R5", "of", int'(out_of), int'(e.of));
        check("R6", "zf", int'(out_zf), int'(e.zf));
        check("R6", "sf", int'(out_sf), int'(e.sf));
        check("R7", "pf", int'(out_pf), int'(e.pf));
        check("R7", "af", int'(out_af), int'(e.af));
      end
    end
  end

  // R9: stalled output holds
  logic          was_stalled = 1'b0;
  logic [W+5:0]  held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled)
        check("R9", "stall hold", int'({out_valid, out_result, out_cf, out_of, out_zf, out_sf, out_pf, out_af}),
              int'({1'b1, held}));
      was_stalled = out_valid && !out_ready;
      held = {out_result, out_cf, out_of, out_zf, out_sf, out_pf, out_af};
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "out_valid in reset", int'(out_valid), 0);
    check("R10", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // worked vectors
    send(3'd0, 1'b0, 16'h1234, 16'h00CD, 1'b0); // R1 0x1301
    send(3'd1, 1'b1, 16'h00AB, 16'h0005, 1'b0); // R1 0xB0
    send(3'd6, 1'b1, 16'h00B0, 16'h0000, 1'b0); // R2 0x50
    send(3'd3, 1'b0, 16'h1301, 16'h0012, 1'b0); // R2 0x12EF
    send(3'd2, 1'b0, 16'h00CD, 16'h0000, 1'b0); // R1 0x00CE
    // corners
    send(3'd2, 1'b1, 16'h007F, 16'h0000, 1'b1); // R5 R4 OF, CF kept
    send(3'd5, 1'b1, 16'h0000, 16'h0000, 1'b0); // R4 DEC keeps CF=0
    send(3'd5, 1'b0, 16'h8000, 16'h0000, 1'b1); // R5 word OF
    send(3'd6, 1'b1, 16'h0080, 16'h0000, 1'b0); // R5 R8 most negative
    send(3'd6, 1'b0, 16'h8000, 16'h0000, 1'b0); // R5 word most negative
    send(3'd6, 1'b0, 16'h0000, 16'h0000, 1'b1); // R8 negate zero
    send(3'd6, 1'b1, 16'hFF00, 16'h0000, 1'b1); // R3 R8 byte zero, upper ignored
    send(3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1); // R4 ADC carry chain
    send(3'd4, 1'b1, 16'h0010, 16'h0010, 1'b1); // R4 R7 SBB borrow
    send(3'd4, 1'b0, 16'h8000, 16'h0001, 1'b0); // R5 word SBB OF
    send(3'd7, 1'b1, 16'hAB70, 16'h5510, 1'b1); // R1 R3 alt add, upper ignored
    send(3'd0, 1'b1, 16'h0003, 16'h0000, 1'b0); // R7 even parity
    send(3'd3, 1'b1, 16'h0080, 16'h0001, 1'b0); // R5 byte SUB OF

    // random with back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send(3'($urandom % 8), 1'($urandom % 2), 16'($urandom), 16'($urandom), 1'($urandom % 2));
      if (($urandom % 4) == 0) begin
        @(posedge clk);
        #1;
      end
    end
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check("R9", "results received", n_recv, n_sent);
    check("R9", "scoreboard empty", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule